// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block sits in the fetch stage of a processor whose instructions are 1, 2, 5 or 6 bytes long. It takes the current program counter and the six bytes fetched starting at that address. From these it extracts the operation and function nibbles, the two register specifiers and the 32-bit constant. It also reports whether a register byte and a constant word are present, flags unknown opcodes, and computes the address of the following instruction.

The logic is purely combinational. The instruction length and the position of the constant follow only from the high nibble of the first byte. When a register byte is present, the constant starts one byte later. Memory, the PC register and the later pipeline stages sit outside this block.

Top module: `ifetch_decode`

## Requirements
- R1: `icode_o` equals bits 7:4 of fetch byte 0 and `ifun_o` equals bits 3:4-4 of it, that is, bits 3:0. Fetch byte k sits in `ibytes_i[8k+7:8k]`. Both nibbles are passed through unchanged for every opcode, including the invalid ones.
- R2: `valid_o` is 1 exactly when the opcode nibble is in the range 0x0 to 0xB.
- R3: `has_reg_o` is 1 exactly for opcodes 0x2, 0x3, 0x4, 0x5, 0x6, 0xA and 0xB. For these opcodes, `ra_o` is bits 7:4 of byte 1 and `rb_o` is bits 3:0 of byte 1.
- R4: When `has_reg_o` is 0, both `ra_o` and `rb_o` read 0x8, the code for "no register".
- R5: `has_const_o` is 1 exactly for opcodes 0x3, 0x4, 0x5, 0x7 and 0x8. When a register byte is also present, `const_o` is bytes 2 to 5 read little-endian, with byte 2 as the least significant. For example, bytes 30 82 cd ab 00 00 give 0x0000abcd.
- R6: When a constant is present without a register byte, `const_o` is bytes 1 to 4 read little-endian, with byte 1 as the least significant.
- R7: When `has_const_o` is 0, `const_o` is zero.
- R8: `next_pc_o` = `pc_i` + 1 + `has_reg_o` + 4·`has_const_o`, modulo 2^32. This gives lengths of 1, 2, 5 and 6 bytes.
- R9: For opcodes 0xC to 0xF, the outputs other than `icode_o` and `ifun_o` decode as for a no-op: no register byte, no constant, both register IDs 0x8, constant zero and `next_pc_o` = `pc_i` + 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Address of the instruction |
| ibytes_i | input | 48 | Bytes fetched at pc_i through pc_i+5; byte k in bits 8k+7:8k |
| icode_o | output | 4 | Opcode nibble |
| ifun_o | output | 4 | Function nibble |
| ra_o | output | 4 | First register specifier, 0x8 when absent |
| rb_o | output | 4 | Second register specifier, 0x8 when absent |
| const_o | output | 32 | Little-endian constant word, zero when absent |
| next_pc_o | output | 32 | Address of the following instruction |
| valid_o | output | 1 | Opcode is defined |
| has_reg_o | output | 1 | Register byte present |
| has_const_o | output | 1 | Constant word present |

## Verification
Every result of this block is due in the same cycle as the stimulus that produces it, because no register lies on any path. The bench applies each fetch window just after a rising edge and reads all outputs at the following falling edge, half a period later, once the decode has settled. The opcode sweep covers all sixteen opcode values, each against several byte patterns and PC values, one of them close to the top of the address space so that the next-PC sum wraps.

// File: rtl/ifd_pkg.sv
package ifd_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 8;

  typedef enum logic [NIB_W-1:0] {
    OP_NOP    = 4'h0,
    OP_HALT   = 4'h1,
    OP_MOV_RR = 4'h2,
    OP_MOV_IR = 4'h3,
    OP_MOV_RM = 4'h4,
    OP_MOV_MR = 4'h5,
    OP_ALU    = 4'h6,
    OP_JUMP   = 4'h7,
    OP_CALL   = 4'h8,
    OP_RET    = 4'h9,
    OP_PUSH   = 4'hA,
    OP_POP    = 4'hB
  } opcode_e;

  localparam logic [NIB_W-1:0] REG_NONE = 4'h8;
endpackage

// File: rtl/ifd_class.sv
module ifd_class
  import ifd_pkg::*;
(
  input  logic [NIB_W-1:0] icode_i,
  output logic             valid_o,
  output logic             has_reg_o,
  output logic             has_const_o
);
  always_comb begin
    valid_o     = 1'b1;
    has_reg_o   = 1'b0;
    has_const_o = 1'b0;
    case (icode_i)
      OP_NOP, OP_HALT, OP_RET: ;
      OP_MOV_RR, OP_ALU, OP_PUSH, OP_POP: has_reg_o = 1'b1;
      OP_MOV_IR, OP_MOV_RM, OP_MOV_MR: begin
        has_reg_o   = 1'b1;
        has_const_o = 1'b1;
      end
      OP_JUMP, OP_CALL: has_const_o = 1'b1;
      default: valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ifd_fields.sv
module ifd_fields
  import ifd_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  localparam int FETCH_BYTES = WORD_BYTES + 2,
  localparam int BYTES_W = BYTE_W * FETCH_BYTES,
  localparam int WORD_W  = BYTE_W * WORD_BYTES
) (
  input  logic [BYTES_W-1:0] ibytes_i,
  input  logic               has_reg_i,
  input  logic               has_const_i,
  output logic [NIB_W-1:0]   ra_o,
  output logic [NIB_W-1:0]   rb_o,
  output logic [WORD_W-1:0]  const_o
);
  logic [WORD_W-1:0] word_w;

  // constant starts at byte 2 behind a register byte, else at byte 1
  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_align
    assign word_w[BYTE_W*k +: BYTE_W] = has_reg_i ? ibytes_i[BYTE_W*(k+2) +: BYTE_W]
                                                  : ibytes_i[BYTE_W*(k+1) +: BYTE_W];
  end

  assign ra_o    = has_reg_i ? ibytes_i[BYTE_W+NIB_W +: NIB_W] : REG_NONE;
  assign rb_o    = has_reg_i ? ibytes_i[BYTE_W +: NIB_W]       : REG_NONE;
  assign const_o = has_const_i ? word_w : '0;
endmodule

// File: rtl/ifd_next_pc.sv
module ifd_next_pc #(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              has_reg_i,
  input  logic              has_const_i,
  output logic [ADDR_W-1:0] next_pc_o
);
  logic [ADDR_W-1:0] incr_w;

  assign incr_w    = ADDR_W'(1) + ADDR_W'(has_reg_i)
                   + (has_const_i ? ADDR_W'(WORD_BYTES) : '0);
  assign next_pc_o = pc_i + incr_w;
endmodule

// File: rtl/ifetch_decode.sv
module ifetch_decode
  import ifd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4,
  localparam int FETCH_BYTES = WORD_BYTES + 2,
  localparam int BYTES_W = BYTE_W * FETCH_BYTES,
  localparam int WORD_W  = BYTE_W * WORD_BYTES
) (
  input  logic [ADDR_W-1:0]  pc_i,
  input  logic [BYTES_W-1:0] ibytes_i,
  output logic [NIB_W-1:0]   icode_o,
  output logic [NIB_W-1:0]   ifun_o,
  output logic [NIB_W-1:0]   ra_o,
  output logic [NIB_W-1:0]   rb_o,
  output logic [WORD_W-1:0]  const_o,
  output logic [ADDR_W-1:0]  next_pc_o,
  output logic               valid_o,
  output logic               has_reg_o,
  output logic               has_const_o
);
  assign icode_o = ibytes_i[NIB_W +: NIB_W];
  assign ifun_o  = ibytes_i[0 +: NIB_W];

  ifd_class i_class (
    .icode_i     (icode_o),
    .valid_o     (valid_o),
    .has_reg_o   (has_reg_o),
    .has_const_o (has_const_o)
  );

  ifd_fields #(.WORD_BYTES(WORD_BYTES)) i_fields (
    .ibytes_i    (ibytes_i),
    .has_reg_i   (has_reg_o),
    .has_const_i (has_const_o),
    .ra_o        (ra_o),
    .rb_o        (rb_o),
    .const_o     (const_o)
  );

  ifd_next_pc #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) i_next_pc (
    .pc_i        (pc_i),
    .has_reg_i   (has_reg_o),
    .has_const_i (has_const_o),
    .next_pc_o   (next_pc_o)
  );

  logic [ADDR_W-1:0] len_w;
  assign len_w = next_pc_o - pc_i;

  always_comb begin
    // R8
    len_set_chk: assert (len_w == ADDR_W'(1) || len_w == ADDR_W'(2) ||
                         len_w == ADDR_W'(WORD_BYTES + 1) || len_w == ADDR_W'(WORD_BYTES + 2));
    // R4
    no_reg_id_chk: assert (has_reg_o || (ra_o == REG_NONE && rb_o == REG_NONE));
    // R7
    const_zero_chk: assert (has_const_o || const_o == '0);
    // R9
    invalid_nop_chk: assert (valid_o || (!has_reg_o && !has_const_o && len_w == ADDR_W'(1)));
    // R2
    field_valid_chk: assert (!(has_reg_o || has_const_o) || valid_o);
  end
endmodule

// File: tb/test_ifetch_decode.sv
module test_ifetch_decode;
  logic        clk;
  logic        rst_ni;
  logic [31:0] pc_i;
  logic [47:0] ibytes_i;
  logic [3:0]  icode_o, ifun_o, ra_o, rb_o;
  logic [31:0] const_o, next_pc_o;
  logic        valid_o, has_reg_o, has_const_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  ifetch_decode i_ifetch_decode (
    .pc_i(pc_i), .ibytes_i(ibytes_i),
    .icode_o(icode_o), .ifun_o(ifun_o), .ra_o(ra_o), .rb_o(rb_o),
    .const_o(const_o), .next_pc_o(next_pc_o), .valid_o(valid_o),
    .has_reg_o(has_reg_o), .has_const_o(has_const_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] pc, input logic [47:0] b);
    logic [3:0]  c;
    logic        er, ec, ev;
    logic [31:0] econst;
    @(posedge clk);
    pc_i     <= pc;
    ibytes_i <= b;
    @(negedge clk);
    c  = b[7:4];
    ev = (c <= 4'hB);
    er = (c == 4'h2 || c == 4'h3 || c == 4'h4 || c == 4'h5 ||
          c == 4'h6 || c == 4'hA || c == 4'hB);
    ec = (c == 4'h3 || c == 4'h4 || c == 4'h5 || c == 4'h7 || c == 4'h8);
    econst = 32'h0;
    if (ec && er)  econst = {b[47:40], b[39:32], b[31:24], b[23:16]};
    if (ec && !er) econst = {b[39:32], b[31:24], b[23:16], b[15:8]};
    chk("R1 icode", 32'(icode_o), 32'(c));
    chk("R1 ifun", 32'(ifun_o), 32'(b[3:0]));
    chk("R2 valid", 32'(valid_o), 32'(ev));
    chk("R3 has_reg", 32'(has_reg_o), 32'(er));
    chk("R3/R4 ra", 32'(ra_o), er ? 32'(b[15:12]) : 32'h8);
    chk("R3/R4 rb", 32'(rb_o), er ? 32'(b[11:8]) : 32'h8);
    chk("R5 has_const", 32'(has_const_o), 32'(ec));
    chk(er ? "R5 const" : (ec ? "R6 const" : "R7 const"), const_o, econst);
    chk(ev ? "R8 next_pc" : "R9 next_pc", next_pc_o,
        pc + 32'd1 + 32'(er) + (ec ? 32'd4 : 32'd0));
  endtask

  initial begin
    #200000;
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [47:0] seed;
    rst_ni   = 1'b0;
    pc_i     = '0;
    ibytes_i = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    // all-zero window: no-op at address 0
    @(negedge clk);
    chk("R8 reset-state next_pc", next_pc_o, 32'h1);
    chk("R4 reset-state ra", 32'(ra_o), 32'h8);

    // directed little-endian cases
    apply(32'h0000_0100, 48'h0000_abcd_8230);
    chk("R5 example const", const_o, 32'h0000_abcd);
    chk("R3 example rb", 32'(rb_o), 32'h2);
    apply(32'h0000_0010, 48'h0000_0000_2880);
    chk("R6 call const", const_o, 32'h0000_0028);
    chk("R8 call next_pc", next_pc_o, 32'h0000_0015);
    apply(32'hFFFF_FFFE, 48'hFFFF_FFF4_1550);
    chk("R8 wrap next_pc", next_pc_o, 32'h0000_0004);

    // sweep all opcodes against several byte patterns and PCs
    seed = 48'h1234_5678_9ABC;
    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < 5; p++) begin
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 7);
        seed = seed ^ (seed << 17);
        apply((p == 4) ? 32'hFFFF_FFFC : seed[39:8],
              {seed[47:8], 4'(c), seed[3:0]});
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule